// File: doc/BRIEF.md
# Four-Channel PWM Generator with Shadowed Period and Phase

This block produces one pulse-width-modulated waveform per channel from a single clock. Software programs each channel through a simple write bus with a period length and a phase length. The phase length is the number of clock cycles spent at the "first" level in each period. The values written on the bus are only staged. The counter runs from working copies that are loaded when the channel is switched on. After that, they change only when software pulses the channel's update bit, and even then only at the next period boundary. This keeps a running waveform free of torn periods.

A per-channel polarity bit chooses which level the phase length measures. A per-channel output-enable bit drives the pad direction. A stopped channel holds its output low. Reads on a separate combinational port return what was programmed.

Top module: `shadow_pwm`

## Requirements
- R1: Channel n's phase field is at byte address n*8 and its period field is at n*8+4. Both fields keep only bits [29:0] of the written data, and a read returns them zero-extended; for example, writing 0xFFFFFFFF reads back as 0x3FFFFFFF. Unmapped addresses read 0.
- R2: The control vectors use bit n for channel n. Polarity is at 0x40, run is at 0x44, update is at 0x4C and output enable is at 0xD0. Each one reads back its value in bits [3:0].
- R3: After reset, every register reads 0, and both pwm_out and pad_oe are 0.
- R4: A 0-to-1 change of a run bit copies that channel's period and phase into working copies and clears its counter. From the cycle after that write, cycle i of each period (i = 0 .. period-1) is low when i < phase and high otherwise, provided the polarity bit is 0.
- R5: Writing the period or phase of a running channel does not alter its waveform.
- R6: A 0-to-1 change of an update bit reloads that channel's working copies from its period and phase fields at the next period boundary. The period that is in progress completes unchanged.
- R7: A channel whose run bit is 0 drives pwm_out low, starting the cycle after the write that clears the bit.
- R8: With polarity 0, a phase of 0 gives a constant high output while the channel runs.
- R9: With polarity 1, the output is high for the first phase cycles of each period and low for the rest. A phase of 0 then gives a constant low output. A polarity change takes effect on the next cycle.
- R10: pad_oe[n] equals output-enable bit n from the cycle after it is written. It has no effect on pwm_out.
- R11: A period of 2 with a phase of 1 toggles the output every cycle, which is half the clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, combinational |
| pwm_out | output | 4 | Waveform output, one bit per channel |
| pad_oe | output | 4 | Pad output enable, one bit per channel |

## Verification
A write takes effect at the clock edge that samples it, so register reads, pad_oe and any run, stop or polarity change are visible one cycle later. Counter cycle 0 of a newly started channel is that same following cycle. A reload requested through the update bit appears only on the first cycle after the current period ends. The bench steps a behavioural model at each rising edge using the same bus inputs. It compares pwm_out and pad_oe at the falling edge, so every cycle is checked with this latency already applied. Reads are checked combinationally between edges.

// File: rtl/shadow_pwm.sv
module shadow_pwm #(
  parameter int NCH = 4,
  parameter int PW  = 30,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pad_oe
);
  localparam logic [AW-1:0] A_POL = AW'(8'h40);
  localparam logic [AW-1:0] A_RUN = AW'(8'h44);
  localparam logic [AW-1:0] A_UPD = AW'(8'h4C);
  localparam logic [AW-1:0] A_OE  = AW'(8'hD0);

  logic [NCH-1:0][PW-1:0] ph_q, pr_q, wk_ph, wk_pr, cnt;
  logic [NCH-1:0] pol_q, run_q, upd_q, oe_q, pend;

  wire wr_run = wr_en && wr_addr == A_RUN;
  wire wr_upd = wr_en && wr_addr == A_UPD;
  wire [NCH-1:0] run_rise = {NCH{wr_run}} & wr_data[NCH-1:0] & ~run_q;
  wire [NCH-1:0] upd_rise = {NCH{wr_upd}} & wr_data[NCH-1:0] & ~upd_q;

  logic [NCH-1:0] bnd;
  always_comb
    for (int n = 0; n < NCH; n++)
      bnd[n] = ({1'b0, cnt[n]} + (PW+1)'(1)) >= {1'b0, wk_pr[n]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0; pr_q <= '0; wk_ph <= '0; wk_pr <= '0; cnt <= '0;
      pol_q <= '0; run_q <= '0; upd_q <= '0; oe_q <= '0; pend <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (run_rise[n]) begin
          wk_ph[n] <= ph_q[n];
          wk_pr[n] <= pr_q[n];
          cnt[n]   <= '0;
          pend[n]  <= 1'b0;
        end else if (!run_q[n]) begin
          cnt[n]  <= '0;
          pend[n] <= 1'b0;
        end else begin
          if (bnd[n]) begin
            cnt[n] <= '0;
            if (pend[n]) begin
              wk_ph[n] <= ph_q[n];
              wk_pr[n] <= pr_q[n];
              pend[n]  <= 1'b0;
            end
          end else begin
            cnt[n] <= cnt[n] + PW'(1);
          end
          if (upd_rise[n]) pend[n] <= 1'b1;
        end
        if (wr_en && wr_addr == AW'(n*8))   ph_q[n] <= wr_data[PW-1:0];
        if (wr_en && wr_addr == AW'(n*8+4)) pr_q[n] <= wr_data[PW-1:0];
      end
      if (wr_en && wr_addr == A_POL) pol_q <= wr_data[NCH-1:0];
      if (wr_run) run_q <= wr_data[NCH-1:0];
      if (wr_upd) upd_q <= wr_data[NCH-1:0];
      if (wr_en && wr_addr == A_OE) oe_q <= wr_data[NCH-1:0];
    end
  end

  always_comb
    for (int n = 0; n < NCH; n++)
      pwm_out[n] = run_q[n] & (pol_q[n] ? (cnt[n] < wk_ph[n]) : (cnt[n] >= wk_ph[n]));

  assign pad_oe = oe_q;

  always_comb begin
    rd_data = '0;
    for (int n = 0; n < NCH; n++) begin
      if (rd_addr == AW'(n*8))   rd_data = DW'(ph_q[n]);
      if (rd_addr == AW'(n*8+4)) rd_data = DW'(pr_q[n]);
    end
    if (rd_addr == A_POL) rd_data = DW'(pol_q);
    if (rd_addr == A_RUN) rd_data = DW'(run_q);
    if (rd_addr == A_UPD) rd_data = DW'(upd_q);
    if (rd_addr == A_OE)  rd_data = DW'(oe_q);
  end
endmodule

// File: rtl/shadow_pwm_chk.sv
module shadow_pwm_chk #(
  parameter int NCH = 4,
  parameter int PW  = 30,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [DW-1:0]          wr_data,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         pad_oe,
  input logic [NCH-1:0]         run_q,
  input logic [NCH-1:0][PW-1:0] cnt,
  input logic [NCH-1:0][PW-1:0] wk_pr
);
  p_pad_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(8'hD0)) |=> pad_oe == $past(wr_data[NCH-1:0]));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    p_stop_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(8'h44) && !wr_data[n]) |=> !pwm_out[n]);

    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(8'h44) && wr_data[n] && !run_q[n]) |=> cnt[n] == '0);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[n] && wk_pr[n] >= PW'(2)) |-> cnt[n] < wk_pr[n]);

    p_shadow_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[n] && cnt[n] == '0 && wk_pr[n] >= PW'(2) &&
       !(wr_en && wr_addr == AW'(8'h44))) |=> $stable(wk_pr[n]));
  end
endmodule

bind shadow_pwm shadow_pwm_chk #(.NCH(NCH), .PW(PW), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_out(pwm_out), .pad_oe(pad_oe), .run_q(run_q), .cnt(cnt), .wk_pr(wk_pr)
);

// File: tb/shadow_pwm_test.sv
module shadow_pwm_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R3";

  int m_ph[4], m_pr[4], m_wph[4], m_wpr[4], m_cnt[4];
  bit m_pend[4];
  logic [3:0] m_pol = 0, m_run = 0, m_upd = 0, m_oe = 0;

  shadow_pwm uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .pad_oe(pad_oe));

  always #5 clk = ~clk;

  function automatic void model();
    logic [3:0] old_run = m_run, old_upd = m_upd, rise, urise;
    if (wr_en) begin
      if (wr_addr < 8'h20 && wr_addr[1:0] == 0) begin
        if (wr_addr[2]) m_pr[wr_addr/8] = int'(wr_data & 32'h3FFFFFFF);
        else            m_ph[wr_addr/8] = int'(wr_data & 32'h3FFFFFFF);
      end
      case (wr_addr)
        8'h40: m_pol = wr_data[3:0];
        8'h44: m_run = wr_data[3:0];
        8'h4C: m_upd = wr_data[3:0];
        8'hD0: m_oe  = wr_data[3:0];
        default: ;
      endcase
    end
    rise = m_run & ~old_run;
    urise = m_upd & ~old_upd;
    for (int n = 0; n < 4; n++) begin
      if (rise[n]) begin
        m_wph[n] = m_ph[n]; m_wpr[n] = m_pr[n]; m_cnt[n] = 0; m_pend[n] = 0;
      end else if (!old_run[n]) begin
        m_cnt[n] = 0; m_pend[n] = 0;
      end else begin
        if (m_cnt[n] + 1 >= m_wpr[n]) begin
          m_cnt[n] = 0;
          if (m_pend[n]) begin
            m_wph[n] = m_ph[n]; m_wpr[n] = m_pr[n]; m_pend[n] = 0;
          end
        end else m_cnt[n]++;
        if (urise[n]) m_pend[n] = 1;
      end
    end
  endfunction

  task automatic compare();
    logic [3:0] exp_out;
    for (int n = 0; n < 4; n++)
      exp_out[n] = m_run[n] && (m_pol[n] ? (m_cnt[n] < m_wph[n]) : (m_cnt[n] >= m_wph[n]));
    checks++;
    if (pwm_out !== exp_out) begin
      errors++;
      $display("FAIL %s pwm_out actual=%b expected=%b", cur_req, pwm_out, exp_out);
    end
    checks++;
    if (pad_oe !== m_oe) begin  // R10
      errors++;
      $display("FAIL R10 pad_oe actual=%b expected=%b", pad_oe, m_oe);
    end
  endtask

  task automatic step();
    @(posedge clk); model();
    @(negedge clk); compare();
  endtask

  task automatic idle(int k);
    repeat (k) step();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd_check(logic [7:0] a, logic [31:0] exp, string req);
    rd_addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s read 0x%0h actual=0x%0h expected=0x%0h", req, a, rd_data, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    compare();
    rd_check(8'h00, 0, "R3"); rd_check(8'h44, 0, "R3"); rd_check(8'hD0, 0, "R3");
    idle(2);
    // R4 start latches and counts
    cur_req = "R4";
    wr(8'h00, 2); wr(8'h04, 5); wr(8'h44, 1); idle(12);
    // R5 staged write does not touch the running waveform
    cur_req = "R5";
    wr(8'h00, 4); wr(8'h04, 7); idle(10);
    // R6 update applies at the boundary
    cur_req = "R6";
    wr(8'h4C, 1); wr(8'h4C, 0); idle(16);
    // R8 phase zero gives constant high
    cur_req = "R8";
    wr(8'h08, 0); wr(8'h0C, 3); wr(8'h44, 3); idle(6);
    // R9 inverted polarity, then phase zero constant low
    cur_req = "R9";
    wr(8'h10, 3); wr(8'h14, 6); wr(8'h40, 4); wr(8'h44, 7); idle(12);
    wr(8'h10, 0); wr(8'h4C, 4); wr(8'h4C, 0); idle(10);
    // R11 half-rate toggling
    cur_req = "R11";
    wr(8'h18, 1); wr(8'h1C, 2); wr(8'h44, 15); idle(8);
    // R10 output enable leaves pwm_out alone
    cur_req = "R10";
    wr(8'hD0, 5); idle(3);
    rd_check(8'hD0, 5, "R10");
    // R2 control readback
    rd_check(8'h40, 4, "R2"); rd_check(8'h44, 15, "R2"); rd_check(8'h4C, 0, "R2");
    // R1 field width and map
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_check(8'h0C, 32'h3FFF_FFFF, "R1"); rd_check(8'h10, 0, "R1");
    rd_check(8'h04, 7, "R1"); rd_check(8'h60, 0, "R1");
    // R7 stopped channel is low
    cur_req = "R7";
    wr(8'h44, 14); idle(4);
    checks++;
    if (pwm_out[0] !== 1'b0) begin
      errors++;
      $display("FAIL R7 pwm_out[0] actual=%b expected=0", pwm_out[0]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule